// File: doc/BRIEF.md
# Expansion Card Autoconfiguration Slave

This block takes part in the start-up configuration of a plug-in card on a daisy-chained expansion bus. After reset the card is unmapped. While its upstream neighbour holds the active-low chain enable low, the card answers host cycles that fall in a fixed configuration window. The host then does one of two things with a configuration write. It can give the card a 16 MB region by writing the top address byte of that region. It can instead tell the card to stay silent. Either command releases the chain to the next slot by driving the chain output low.

Once mapped, the card claims every full cycle whose top address byte equals the latched base byte. It stops answering the configuration window. A silenced card claims nothing at all until the next reset. On every claimed cycle the block raises a slave-response output and a cache-inhibit output, because the card's space holds I/O devices. Both outputs are combinational from the current cycle's inputs and the registered state, so they are valid in the same cycle as the strobe. The ID ROM contents and the data paths are outside this block.

Top module: `autocfgSlave`

## Requirements
- R1: Reset leaves the card unmapped with the chain output `cfgOutN` high and the base byte cleared. A base value latched before a reset is not decoded after it.
- R2: While unmapped, the card claims a cycle only when `cycleStrobe` is high, `cfgInN` is low, and `addr[31:16]` equals 16'hFF00 (the configuration window).
- R3: While `cfgInN` is high and the card is unmapped, window cycles are not claimed and configuration writes leave `cfgOutN` high.
- R4: A window cycle with `cfgWrite` high and `readCycle` low at offset `addr[15:0]` = 16'h0048 latches `wrData` as the region byte. From the next cycle on, `cfgOutN` is low.
- R5: Once mapped, a strobed cycle is claimed exactly when `addr[31:24]` equals the latched byte. The configuration window is no longer answered.
- R6: A window configuration write at offset 16'h004C silences the card. `cfgOutN` goes low from the next cycle, and no address is claimed until reset.
- R7: `cacheInhibit` is high on every claimed cycle and low on every other cycle, so it always equals `slaveOut`.
- R8: Without `cycleStrobe` nothing is claimed.
- R9: A window cycle that is a read, has `cfgWrite` low, or hits any offset other than the two command offsets leaves the card unmapped.
- R10: After mapping, writes to the configuration window do not change the latched region byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgInN | input | 1 | Active-low chain enable from the upstream slot |
| addr | input | 32 | Bus address of the current cycle |
| readCycle | input | 1 | 1 = read, 0 = write |
| cycleStrobe | input | 1 | Full-cycle strobe, high while a cycle is in progress |
| cfgWrite | input | 1 | Configuration-register write qualifier |
| wrData | input | 8 | Write data byte carrying the region byte |
| slaveOut | output | 1 | High when the card claims the current cycle |
| cacheInhibit | output | 1 | High on claimed cycles |
| cfgOutN | output | 1 | Active-low chain enable to the downstream slot |

## Verification
Faults in the state register or the base byte show up in only two ways: the level of `cfgOutN` and which addresses `slaveOut` claims.
- A card stuck unmapped keeps `cfgOutN` high one cycle after a valid command and keeps answering the window.
- A card that leaves the unmapped state on a bad command drops `cfgOutN` one cycle early.
- A wrong or stale base byte is exposed by the first strobed cycle to the intended region or to the old one, in that same cycle.

The stimulus therefore probes both sides of every region boundary and of the window, before and after each command, and again after a reset.

// File: rtl/autocfgPkg.sv
package autocfgPkg;
  typedef enum logic [1:0] {
    CFG_IDLE   = 2'd0,
    CFG_MAPPED = 2'd1,
    CFG_SILENT = 2'd2
  } cfgState_e;

  typedef struct packed {
    logic loadBase;
  } pathCtl_t;
endpackage

// File: rtl/autocfgPath.sv
module autocfgPath
  import autocfgPkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned REGION_BITS = 8,
  parameter int unsigned WIN_BITS    = 16,
  parameter logic [WIN_BITS-1:0] WIN_TAG = 16'hFF00,
  parameter int unsigned OFS_BITS    = ADDR_W - WIN_BITS
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [REGION_BITS-1:0] wrData,
  input  pathCtl_t               ctl,
  output logic                   windowHit,
  output logic                   regionHit,
  output logic [OFS_BITS-1:0]    regOfs
);
  logic [REGION_BITS-1:0] baseByte;

  // region byte register, loaded only on the accepted base command
  always_ff @(posedge clk) begin
    if (!rstN)             baseByte <= '0;
    else if (ctl.loadBase) baseByte <= wrData;
  end

  assign windowHit = (addr[ADDR_W-1 -: WIN_BITS] == WIN_TAG);
  assign regionHit = (addr[ADDR_W-1 -: REGION_BITS] == baseByte);
  assign regOfs    = addr[OFS_BITS-1:0];
endmodule

// File: rtl/autocfgCtrl.sv
module autocfgCtrl
  import autocfgPkg::*;
#(
  parameter int unsigned OFS_BITS = 16,
  parameter int unsigned BASE_OFS = 'h48,
  parameter int unsigned SHUT_OFS = 'h4C
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgInN,
  input  logic                readCycle,
  input  logic                cycleStrobe,
  input  logic                cfgWrite,
  input  logic                windowHit,
  input  logic                regionHit,
  input  logic [OFS_BITS-1:0] regOfs,
  output pathCtl_t            ctl,
  output logic                slaveOut,
  output logic                cacheInhibit,
  output logic                cfgOutN
);
  cfgState_e state, stateNext;
  logic cfgAccess, cfgWr, hitBase, hitShut, claim;

  assign cfgAccess = cycleStrobe && !cfgInN && windowHit && (state == CFG_IDLE);
  assign cfgWr     = cfgAccess && cfgWrite && !readCycle;
  assign hitBase   = cfgWr && (regOfs == OFS_BITS'(BASE_OFS));
  assign hitShut   = cfgWr && (regOfs == OFS_BITS'(SHUT_OFS));

  always_comb begin
    stateNext = state;
    if (state == CFG_IDLE) begin
      if (hitBase)      stateNext = CFG_MAPPED;
      else if (hitShut) stateNext = CFG_SILENT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= CFG_IDLE;
    else       state <= stateNext;
  end

  assign claim        = cfgAccess || (cycleStrobe && (state == CFG_MAPPED) && regionHit);
  assign slaveOut     = claim;
  assign cacheInhibit = claim;
  assign cfgOutN      = (state == CFG_IDLE);
  assign ctl.loadBase = hitBase;
endmodule

// File: rtl/autocfgSlave.sv
module autocfgSlave
  import autocfgPkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned REGION_BITS = 8,
  parameter int unsigned WIN_BITS    = 16,
  parameter logic [WIN_BITS-1:0] WIN_TAG = 16'hFF00,
  parameter int unsigned BASE_OFS    = 'h48,
  parameter int unsigned SHUT_OFS    = 'h4C
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgInN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   readCycle,
  input  logic                   cycleStrobe,
  input  logic                   cfgWrite,
  input  logic [REGION_BITS-1:0] wrData,
  output logic                   slaveOut,
  output logic                   cacheInhibit,
  output logic                   cfgOutN
);
  localparam int unsigned OFS_BITS = ADDR_W - WIN_BITS;

  pathCtl_t            ctl;
  logic                windowHit, regionHit;
  logic [OFS_BITS-1:0] regOfs;

  autocfgPath #(
    .ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS), .WIN_BITS(WIN_BITS),
    .WIN_TAG(WIN_TAG), .OFS_BITS(OFS_BITS)
  ) u_path (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .ctl(ctl),
    .windowHit(windowHit), .regionHit(regionHit), .regOfs(regOfs)
  );

  autocfgCtrl #(
    .OFS_BITS(OFS_BITS), .BASE_OFS(BASE_OFS), .SHUT_OFS(SHUT_OFS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgInN(cfgInN), .readCycle(readCycle),
    .cycleStrobe(cycleStrobe), .cfgWrite(cfgWrite), .windowHit(windowHit),
    .regionHit(regionHit), .regOfs(regOfs), .ctl(ctl), .slaveOut(slaveOut),
    .cacheInhibit(cacheInhibit), .cfgOutN(cfgOutN)
  );
endmodule

// File: rtl/autocfgSlaveChk.sv
module autocfgSlaveChk #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned WIN_BITS = 16,
  parameter logic [WIN_BITS-1:0] WIN_TAG = 16'hFF00
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgInN,
  input logic [ADDR_W-1:0] addr,
  input logic              readCycle,
  input logic              cycleStrobe,
  input logic              cfgWrite,
  input logic              slaveOut,
  input logic              cacheInhibit,
  input logic              cfgOutN
);
  // R2: an unmapped card only answers enabled window cycles
  assert_window_only_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgOutN && slaveOut) |-> (!cfgInN && addr[ADDR_W-1 -: WIN_BITS] == WIN_TAG));

  // R3: with the chain enable inactive, an unmapped card stays unmapped
  assert_chain_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgInN && cfgOutN) |=> cfgOutN);

  // R4 and R6: the chain output drops only after an enabled configuration write
  assert_cfgout_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cfgOutN) |-> $past(cycleStrobe && cfgWrite && !readCycle && !cfgInN));

  // R6: once released, the chain output stays low until reset
  assert_cfgout_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    !cfgOutN |=> !cfgOutN);

  // R7: cache inhibit accompanies every claim
  assert_cinh_match_R7: assert property (@(posedge clk) disable iff (!rstN)
    cacheInhibit == slaveOut);

  // R8: no claim without a cycle in progress
  assert_no_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cycleStrobe |-> !slaveOut);
endmodule

bind autocfgSlave autocfgSlaveChk #(
  .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .WIN_TAG(WIN_TAG)
) u_chk (
  .clk(clk), .rstN(rstN), .cfgInN(cfgInN), .addr(addr), .readCycle(readCycle),
  .cycleStrobe(cycleStrobe), .cfgWrite(cfgWrite), .slaveOut(slaveOut),
  .cacheInhibit(cacheInhibit), .cfgOutN(cfgOutN)
);

// File: tb/autocfgSlave_bench.sv
module autocfgSlave_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgInN = 1'b1;
  logic [31:0] addr = '0;
  logic        readCycle = 1'b1;
  logic        cycleStrobe = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [7:0]  wrData = '0;
  logic        slaveOut, cacheInhibit, cfgOutN;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  autocfgSlave u_autocfgSlave (
    .clk(clk), .rstN(rstN), .cfgInN(cfgInN), .addr(addr), .readCycle(readCycle),
    .cycleStrobe(cycleStrobe), .cfgWrite(cfgWrite), .wrData(wrData),
    .slaveOut(slaveOut), .cacheInhibit(cacheInhibit), .cfgOutN(cfgOutN)
  );

  typedef struct packed {
    logic        cin;
    logic [31:0] a;
    logic        rd;
    logic        stb;
    logic        cw;
    logic [7:0]  d;
    logic        expSlv;
    logic        expOutN;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 32'hFF00_0000, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 4'd2},  // R2 window read
    '{1'b0, 32'hFF00_0000, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 4'd8},  // R8 no strobe
    '{1'b0, 32'hFE00_0000, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 4'd2},  // R2 outside window
    '{1'b0, 32'hFF00_0048, 1'b1, 1'b1, 1'b1, 8'h40, 1'b1, 1'b1, 4'd9},  // R9 read at base offset
    '{1'b0, 32'hFF00_0050, 1'b0, 1'b1, 1'b1, 8'h40, 1'b1, 1'b1, 4'd9},  // R9 other offset
    '{1'b0, 32'hFF00_0048, 1'b0, 1'b1, 1'b0, 8'h40, 1'b1, 1'b1, 4'd9},  // R9 no cfgWrite
    '{1'b0, 32'hFF00_0048, 1'b0, 1'b1, 1'b1, 8'h40, 1'b1, 1'b0, 4'd4},  // R4 base write
    '{1'b0, 32'h4012_3456, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 4'd5},  // R5 in region
    '{1'b0, 32'h4100_0000, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 4'd5},  // R5 above region
    '{1'b0, 32'h3FFF_FFFF, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 4'd5},  // R5 below region
    '{1'b0, 32'hFF00_0000, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 4'd5},  // R5 window gone
    '{1'b0, 32'hFF00_0048, 1'b0, 1'b1, 1'b1, 8'h20, 1'b0, 1'b0, 4'd10}, // R10 rewrite ignored
    '{1'b0, 32'h2000_0000, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 4'd10}, // R10 new value unused
    '{1'b0, 32'h40FF_FFFF, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 4'd10}  // R10 old value kept
  };

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // drive one cycle; claim outputs are checked in-cycle, cfgOutN after the edge
  task automatic step(input logic cin, input logic [31:0] a, input logic rd, input logic stb,
                      input logic cw, input logic [7:0] d, input logic expSlv,
                      input logic expOutN, input string req);
    @(negedge clk);
    cfgInN = cin; addr = a; readCycle = rd; cycleStrobe = stb; cfgWrite = cw; wrData = d;
    #1;
    check(req, slaveOut, expSlv, $sformatf("slaveOut addr=%h", a));
    check("R7", cacheInhibit, expSlv, $sformatf("cacheInhibit addr=%h", a));
    @(posedge clk); #1;
    check(req, cfgOutN, expOutN, "cfgOutN");
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cycleStrobe = 1'b0; cfgWrite = 1'b0; readCycle = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    doReset();
    #1;
    check("R1", cfgOutN, 1'b1, "cfgOutN after reset");
    check("R1", slaveOut, 1'b0, "slaveOut after reset");

    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i].cin, VECS[i].a, VECS[i].rd, VECS[i].stb, VECS[i].cw, VECS[i].d,
           VECS[i].expSlv, VECS[i].expOutN, $sformatf("R%0d", VECS[i].req));
    end

    // R1: reset unmaps and forgets the base byte
    doReset();
    #1;
    check("R1", cfgOutN, 1'b1, "cfgOutN after second reset");
    step(1'b0, 32'h4000_0000, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, "R1");
    step(1'b0, 32'hFF00_0000, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, "R1");
    step(1'b0, 32'hFF00_0048, 1'b0, 1'b1, 1'b1, 8'h80, 1'b1, 1'b0, "R4");
    step(1'b0, 32'h8000_0000, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R5");
    step(1'b0, 32'h4000_0000, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R1");

    // R3: chain enable inactive
    doReset();
    step(1'b1, 32'hFF00_0000, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, "R3");
    step(1'b1, 32'hFF00_0048, 1'b0, 1'b1, 1'b1, 8'h40, 1'b0, 1'b1, "R3");
    step(1'b1, 32'hFF00_004C, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b1, "R3");
    step(1'b1, 32'h4000_0000, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, "R3");

    // R6: shut-up command silences the card
    step(1'b0, 32'hFF00_004C, 1'b0, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0, "R6");
    step(1'b0, 32'hFF00_0000, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R6");
    step(1'b0, 32'hFF00_0048, 1'b0, 1'b1, 1'b1, 8'h40, 1'b0, 1'b0, "R6");
    step(1'b0, 32'h4000_0000, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R6");
    step(1'b0, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R6");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule